// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Aligner

The aligner sits between a 32-bit big-endian instruction memory port and an instruction decoder. It keeps a small queue of halfwords taken from fetched words, and it hands the decoder one whole instruction per cycle. An instruction is either a 16-bit compact form or a 32-bit extended form. An extended instruction can start at either halfword of a word, so it may begin in one word and end in the next.

The fetch side is a plain valid/ready handshake. The block drives the word address and a request flag. The memory returns the word for that address with a valid flag, and a word is taken in any cycle where both flags are high. A flush input empties the queue and restarts fetching at a new halfword target. A target whose byte bit is set is illegal: the block raises an exception flag and stops fetching and issuing until the next legal flush. The decoder accepts an instruction in any cycle where the issue valid and its ready input are both high.

Top module: `insn_aligner`

## Requirements
- R1: An instruction is extended when bits [15:13] of its first halfword are 3'b111, and compact otherwise. An extended instruction is presented with its first halfword in issue_insn_o[31:16] and its second halfword in [15:0]. A compact instruction appears in [15:0] with [31:16] zero. issue_ext_o gives the length.
- R2: Bits [31:16] of a fetched word are the halfword at the lower address, and bits [15:0] are the halfword at the higher address.
- R3: Each accepted instruction moves issue_pc_o forward by 2 if it is compact and by 4 if it is extended. The issued PC is always even.
- R4: While issue_valid_o is high and dec_ready_i is low, the issued instruction, its length flag and its PC hold steady.
- R5: When memory returns data in every cycle and the decoder is always ready, issue_valid_o stays high in every cycle after the first issue, for any mix of compact, aligned extended and unaligned extended instructions.
- R6: An extended instruction that starts in the higher-address halfword of a word and ends in the next word is issued whole and correctly ordered.
- R7: A flush is registered. In the next cycle the queue is empty, issue_pc_o equals the target, and fetch_addr_o equals the target with bits [1:0] cleared. Each accepted word then moves fetch_addr_o forward by 4.
- R8: After a flush to a target with bit 1 set, bits [31:16] of the first fetched word are discarded, and the first issued instruction starts at the target.
- R9: A flush to a target with bit 0 set raises addr_exc_o from the next cycle. While addr_exc_o is high, issue_valid_o and fetch_req_o stay low. A flush to a legal target clears addr_exc_o.
- R10: issue_valid_o stays low while the queue holds only the first halfword of an extended instruction.
- R11: With the default depth of 4 halfwords, fetch_req_o is high only when at least two slots will be free once this cycle's issue is taken. After reset, issue_valid_o and addr_exc_o are low, and issue_pc_o and fetch_addr_o equal RESET_PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Change of flow; restart at flush_addr_i |
| flush_addr_i | input | AW | New target byte address |
| fetch_req_o | output | 1 | Block can accept a word this cycle |
| fetch_addr_o | output | AW | Word address being fetched |
| fetch_valid_i | input | 1 | fetch_data_i holds the word at fetch_addr_o |
| fetch_data_i | input | 32 | Fetched word, big endian |
| dec_ready_i | input | 1 | Decoder accepts the issued instruction |
| issue_valid_o | output | 1 | A whole instruction is presented |
| issue_insn_o | output | 32 | Issued instruction |
| issue_ext_o | output | 1 | 1 = extended (32-bit), 0 = compact |
| issue_pc_o | output | AW | Address of the issued instruction |
| addr_exc_o | output | 1 | Illegal odd-byte flush target seen |

## Verification
A queue count that is off by one shows up as one of two faults. Either an extended instruction is issued with a stale second halfword, or the request flag and the word address drift away from the instruction stream. Both can be seen within one or two cycles of the fault, in issue_insn_o or fetch_addr_o. If the halfwords are shifted or appended in the wrong place, the wrong bits appear at the very next issue. The bench follows every issued instruction against a model that walks memory from the flush target, so even one misplaced halfword breaks the comparison. It also counts cycles with no issue during sequential flow, which exposes a fetch limit that is too strict.

// File: rtl/insn_aligner.sv
module insn_aligner #(
  parameter int AW = 32,
  parameter int DEPTH = 4,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic [AW-1:0] flush_addr_i,
  output logic          fetch_req_o,
  output logic [AW-1:0] fetch_addr_o,
  input  logic          fetch_valid_i,
  input  logic [31:0]   fetch_data_i,
  input  logic          dec_ready_i,
  output logic          issue_valid_o,
  output logic [31:0]   issue_insn_o,
  output logic          issue_ext_o,
  output logic [AW-1:0] issue_pc_o,
  output logic          addr_exc_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [15:0]   q [DEPTH];
  logic [15:0]   qn [DEPTH];
  logic [CW-1:0] cnt;
  logic [CW-1:0] post;
  logic [1:0]    used;
  logic          skip;
  logic          exc;
  logic          take;
  logic          acc;
  logic [AW-1:0] pc;
  logic [AW-1:0] fa;

  assign issue_ext_o   = q[0][15:13] == 3'b111;
  assign issue_insn_o  = issue_ext_o ? {q[0], q[1]} : {16'h0000, q[0]};
  assign issue_valid_o = !exc && !flush_i && (issue_ext_o ? cnt >= CW'(2) : cnt >= CW'(1));
  assign issue_pc_o    = pc;
  assign fetch_addr_o  = fa;
  assign addr_exc_o    = exc;

  assign take = issue_valid_o && dec_ready_i;
  assign used = take ? (issue_ext_o ? 2'd2 : 2'd1) : 2'd0;
  assign post = cnt - CW'(used);
  assign fetch_req_o = !exc && !flush_i && (int'(post) + 2 <= DEPTH);
  assign acc = fetch_req_o && fetch_valid_i;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      qn[i] = (i + int'(used) < DEPTH) ? q[i + int'(used)] : 16'h0000;
      if (acc && i == int'(post))
        qn[i] = skip ? fetch_data_i[15:0] : fetch_data_i[31:16];
      if (acc && !skip && i == int'(post) + 1)
        qn[i] = fetch_data_i[15:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      skip <= 1'b0;
      exc  <= 1'b0;
      pc   <= RESET_PC;
      fa   <= RESET_PC;
      for (int i = 0; i < DEPTH; i++) q[i] <= 16'h0000;
    end else if (flush_i) begin
      cnt  <= '0;
      pc   <= flush_addr_i;
      fa   <= {flush_addr_i[AW-1:2], 2'b00};
      skip <= flush_addr_i[1];
      exc  <= flush_addr_i[0];
    end else begin
      for (int i = 0; i < DEPTH; i++) q[i] <= qn[i];
      cnt <= post + (acc ? (skip ? CW'(1) : CW'(2)) : CW'(0));
      if (take) pc <= pc + (issue_ext_o ? AW'(4) : AW'(2));
      if (acc) begin
        fa   <= fa + AW'(4);
        skip <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/insn_aligner_chk.sv
module insn_aligner_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush_i,
  input logic [AW-1:0] flush_addr_i,
  input logic          fetch_req_o,
  input logic [AW-1:0] fetch_addr_o,
  input logic          fetch_valid_i,
  input logic          dec_ready_i,
  input logic          issue_valid_o,
  input logic [31:0]   issue_insn_o,
  input logic          issue_ext_o,
  input logic [AW-1:0] issue_pc_o,
  input logic          addr_exc_o
);
  AST_COMPACT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o && !issue_ext_o |-> issue_insn_o[31:16] == 16'h0000); // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o && dec_ready_i |=> issue_pc_o == $past(issue_pc_o) + ($past(issue_ext_o) ? AW'(4) : AW'(2))); // R3
  AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o |-> !issue_pc_o[0]); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o && !dec_ready_i |=> (flush_i || issue_valid_o) && $stable(issue_insn_o) && $stable(issue_pc_o)); // R4
  AST_FLUSH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> issue_pc_o == $past(flush_addr_i) && fetch_addr_o[AW-1:2] == $past(flush_addr_i[AW-1:2]) && fetch_addr_o[1:0] == 2'b00); // R7
  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_o && fetch_valid_i |=> fetch_addr_o == $past(fetch_addr_o) + AW'(4)); // R7
  AST_EXC_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i && flush_addr_i[0] |=> addr_exc_o); // R9
  AST_EXC_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    addr_exc_o |-> !issue_valid_o && !fetch_req_o); // R9
endmodule

bind insn_aligner insn_aligner_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
  .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o), .fetch_valid_i(fetch_valid_i),
  .dec_ready_i(dec_ready_i), .issue_valid_o(issue_valid_o), .issue_insn_o(issue_insn_o),
  .issue_ext_o(issue_ext_o), .issue_pc_o(issue_pc_o), .addr_exc_o(addr_exc_o)
);

// File: tb/insn_aligner_tb.sv
module insn_aligner_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic [31:0] flush_addr_i = '0;
  logic        fetch_req_o;
  logic [31:0] fetch_addr_o;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_data_i;
  logic        dec_ready_i = 1'b0;
  logic        issue_valid_o;
  logic [31:0] issue_insn_o;
  logic        issue_ext_o;
  logic [31:0] issue_pc_o;
  logic        addr_exc_o;

  logic [15:0] mem [64];
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  assign fetch_data_i = {mem[(fetch_addr_o >> 1) & 63], mem[((fetch_addr_o >> 1) + 1) & 63]};

  insn_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o), .fetch_valid_i(fetch_valid_i),
    .fetch_data_i(fetch_data_i), .dec_ready_i(dec_ready_i), .issue_valid_o(issue_valid_o),
    .issue_insn_o(issue_insn_o), .issue_ext_o(issue_ext_o), .issue_pc_o(issue_pc_o),
    .addr_exc_o(addr_exc_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input int seed, input int ext_mask);
    for (int i = 0; i < 64; i++) begin
      logic [12:0] low;
      low = 13'((i * 37 + seed * 11) & 13'h1fff);
      mem[i] = ((ext_mask >> ((i + seed) % 31)) & 1) != 0 ? {3'b111, low} : {3'b010, low};
    end
  endtask

  task automatic do_flush(input logic [31:0] tgt);
    @(negedge clk);
    flush_i = 1'b1;
    flush_addr_i = tgt;
    @(negedge clk);
    flush_i = 1'b0;
  endtask

  function automatic logic [31:0] model_insn(input logic [31:0] pc, output bit ext);
    logic [15:0] h0, h1;
    h0 = mem[(pc >> 1) & 63];
    h1 = mem[((pc >> 1) + 1) & 63];
    ext = h0[15:13] == 3'b111;
    return ext ? {h0, h1} : {16'h0000, h0};
  endfunction

  task automatic run_stream(input logic [31:0] tgt, input int n, input string req);
    logic [31:0] exp_pc;
    int issued;
    int bubbles;
    bit ext;
    logic [31:0] e;
    fetch_valid_i = 1'b1;
    dec_ready_i = 1'b1;
    do_flush(tgt);
    chk(issue_pc_o == tgt, "R7 pc after flush", issue_pc_o, tgt);
    chk(fetch_addr_o == {tgt[31:2], 2'b00}, "R7 fetch addr after flush", fetch_addr_o, {tgt[31:2], 2'b00});
    exp_pc = tgt;
    issued = 0;
    bubbles = 0;
    for (int c = 0; c < 4 * n + 10 && issued < n; c++) begin
      if (issue_valid_o) begin
        e = model_insn(exp_pc, ext);
        chk(issue_insn_o == e, {req, " R1 R2 insn"}, issue_insn_o, e);
        chk(issue_ext_o == ext, {req, " R1 length"}, 32'(issue_ext_o), 32'(ext));
        chk(issue_pc_o == exp_pc, {req, " R3 pc"}, issue_pc_o, exp_pc);
        exp_pc = exp_pc + (ext ? 32'd4 : 32'd2);
        issued++;
      end else if (issued > 0) begin
        bubbles++;
      end
      @(negedge clk);
    end
    chk(issued == n, {req, " issue count"}, 32'(issued), 32'(n));
    chk(bubbles == 0, {req, " R5 no bubble"}, 32'(bubbles), 32'd0);
  endtask

  task automatic t_reset;
    chk(issue_valid_o == 1'b0, "R11 reset valid", 32'(issue_valid_o), 32'd0);
    chk(issue_pc_o == 32'd0, "R11 reset pc", issue_pc_o, 32'd0);
    chk(fetch_addr_o == 32'd0, "R11 reset fetch addr", fetch_addr_o, 32'd0);
    chk(addr_exc_o == 1'b0, "R11 reset exc", 32'(addr_exc_o), 32'd0);
  endtask

  task automatic t_compact;
    fill(1, 0);
    run_stream(32'h0, 20, "compact");
  endtask

  task automatic t_mixed;
    fill(3, 32'h2a5b_6c93);
    run_stream(32'h4, 24, "mixed R6");
    fill(5, 32'h7fff_ffff);
    run_stream(32'h2, 16, "all-ext unaligned R6");
  endtask

  task automatic t_odd_target;
    bit ext;
    logic [31:0] e;
    fill(7, 0);
    mem[4] = 16'hdead;
    mem[5] = 16'h1234;
    fetch_valid_i = 1'b1;
    dec_ready_i = 1'b0;
    do_flush(32'h0a);
    @(negedge clk);
    e = model_insn(32'h0a, ext);
    chk(issue_valid_o == 1'b1, "R8 valid", 32'(issue_valid_o), 32'd1);
    chk(issue_insn_o == 32'h0000_1234, "R8 first halfword dropped", issue_insn_o, 32'h0000_1234);
    chk(issue_pc_o == 32'h0a, "R8 pc", issue_pc_o, 32'h0a);
    run_stream(32'h0a, 12, "odd target R8");
  endtask

  task automatic t_stall;
    logic [31:0] i0, p0;
    fill(9, 32'h0f0f_0f0f);
    fetch_valid_i = 1'b1;
    dec_ready_i = 1'b0;
    do_flush(32'h10);
    @(negedge clk);
    i0 = issue_insn_o;
    p0 = issue_pc_o;
    repeat (5) @(negedge clk);
    chk(issue_valid_o == 1'b1, "R4 valid held", 32'(issue_valid_o), 32'd1);
    chk(issue_insn_o == i0, "R4 insn held", issue_insn_o, i0);
    chk(issue_pc_o == p0, "R4 pc held", issue_pc_o, p0);
    chk(fetch_req_o == 1'b0, "R11 no request when full", 32'(fetch_req_o), 32'd0);
    chk(fetch_addr_o == 32'h18, "R11 fetch stopped after two words", fetch_addr_o, 32'h18);
  endtask

  task automatic t_half_ext;
    bit ext;
    logic [31:0] e;
    fill(11, 0);
    mem[7] = 16'hf00d;
    mem[8] = 16'h5a5a;
    fetch_valid_i = 1'b1;
    dec_ready_i = 1'b1;
    do_flush(32'h0e);
    fetch_valid_i = 1'b0;
    @(negedge clk);
    fetch_valid_i = 1'b1;
    @(negedge clk);
    fetch_valid_i = 1'b0;
    repeat (3) begin
      chk(issue_valid_o == 1'b0, "R10 withheld on half ext", 32'(issue_valid_o), 32'd0);
      @(negedge clk);
    end
    fetch_valid_i = 1'b1;
    @(negedge clk);
    e = model_insn(32'h0e, ext);
    chk(issue_valid_o == 1'b1, "R6 straddle valid", 32'(issue_valid_o), 32'd1);
    chk(issue_insn_o == 32'hf00d_5a5a, "R6 straddle insn", issue_insn_o, 32'hf00d_5a5a);
  endtask

  task automatic t_exc;
    fill(13, 0);
    fetch_valid_i = 1'b1;
    dec_ready_i = 1'b1;
    do_flush(32'h0b);
    repeat (4) begin
      chk(addr_exc_o == 1'b1, "R9 exc raised", 32'(addr_exc_o), 32'd1);
      chk(issue_valid_o == 1'b0, "R9 no issue", 32'(issue_valid_o), 32'd0);
      chk(fetch_req_o == 1'b0, "R9 no fetch", 32'(fetch_req_o), 32'd0);
      @(negedge clk);
    end
    do_flush(32'h08);
    chk(addr_exc_o == 1'b0, "R9 exc cleared", 32'(addr_exc_o), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    fill(0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_compact();
    t_mixed();
    t_odd_target();
    t_stall();
    t_half_ext();
    t_exc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule